// File: doc/BRIEF.md
# Backup Battery Health Probe Sequencer

This block decides whether the backup cell behind a battery-supported SRAM still holds charge. It does this through ordinary memory traffic. A battery-backed memory that finds a weak cell at power-up sets an internal warning and silently drops the first write it receives afterwards. The sequencer uses that behaviour to expose the warning without any dedicated status pin.

After reset, or on a start pulse, the sequencer selects one probe location and reads it. It writes the inverted byte to the same place and reads the location again. If the second read returns the inverted byte, the write went through, so the cell is healthy. The sequencer then puts the first byte back. If the second read returns anything else, the write was swallowed, and the sequencer reports a weak battery so that the system can treat stored data as suspect.

The sequencer reaches memory through a simple request port of a memory controller. A request stays up, with stable address, direction and write data, until the controller acknowledges it for one cycle. For a read, the data arrives in that same acknowledge cycle.

Top module: `bkup_probe_seq`

## Requirements
- R1: While reset is active, `busy_o`, `done_o`, `batt_ok_o`, `batt_low_o` and `mem_req_o` are all 0.
- R2: With `AUTO_START` set, the first check begins after reset is released without any start pulse. The first request is a read (`mem_we_o`=0) of the address present on `probe_addr_i` when the check began.
- R3: The second request is a write (`mem_we_o`=1) of the bitwise inverse of the byte returned by the first read, to the same address.
- R4: The third request is a read of the same address.
- R5: If the third request returns the inverse of the first byte, a fourth request writes the first byte back to the same address. The verdict is `batt_ok_o`=1 and `batt_low_o`=0, and the probed location ends with its original value.
- R6: If the third request returns any other value, the verdict is `batt_low_o`=1 and `batt_ok_o`=0, and no further request is issued.
- R7: A request holds its address, direction and write data until `mem_ack_i` is seen. Exactly one operation takes place per acknowledge, however long the controller waits.
- R8: `done_o` is a single-cycle pulse. `batt_ok_o` and `batt_low_o` are never both 1, are valid during that pulse, and keep their value until the next check begins. At that point both return to 0.
- R9: A start pulse that arrives while a check is running has no effect: the running check completes normally and no second check follows.
- R10: The probe address is captured when a check begins. Later changes on `probe_addr_i` do not alter `mem_addr_o` during that check.
- R11: `busy_o` rises in the cycle after a check begins, stays high up to and including the `done_o` cycle, and is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a check |
| probe_addr_i | input | AW | Location used for the check, captured at the beginning |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | AW | Request address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge from the controller |
| mem_rdata_i | input | DW | Read data, valid with the acknowledge |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a check |
| batt_ok_o | output | 1 | Verdict: backup cell healthy |
| batt_low_o | output | 1 | Verdict: backup cell weak, contents suspect |

## Verification
The check is exercised with a mid-range pattern, with all-ones and all-zeros bytes at the extreme addresses, and with an alternating nibble pattern. The all-ones and all-zeros cases make sure the inversion is a true bitwise complement and not some other change. A memory model that swallows exactly one write separates a weak cell from a healthy one, because the second read then returns the original byte. That run also shows that the restore write is skipped. Controller latencies of zero to five cycles, together with start pulses and address changes injected mid-check, separate correct handshake waiting and address capture from accidental timing.

// File: rtl/bps_pkg.sv
`timescale 1ns/1ps
package bps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_A,
    ST_WRITE_INV,
    ST_READ_B,
    ST_RESTORE,
    ST_FINISH
  } bps_step_e;
endpackage

// File: rtl/bps_ctrl.sv
`timescale 1ns/1ps
module bps_ctrl
  import bps_pkg::*;
#(
  parameter bit AUTO_START = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      ack_i,
  input  logic      match_i,
  output bps_step_e step_o,
  output logic      accept_o,
  output logic      ev_rd_a_o,
  output logic      ev_wr_inv_o,
  output logic      ev_rd_b_o,
  output logic      ev_restore_o
);
  bps_step_e step_q, step_d;
  logic      boot_pend_q;

  assign accept_o     = (step_q == ST_IDLE) && (start_i || boot_pend_q);
  assign ev_rd_a_o    = (step_q == ST_READ_A)    && ack_i;
  assign ev_wr_inv_o  = (step_q == ST_WRITE_INV) && ack_i;
  assign ev_rd_b_o    = (step_q == ST_READ_B)    && ack_i;
  assign ev_restore_o = (step_q == ST_RESTORE)   && ack_i;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:      if (accept_o)     step_d = ST_READ_A;
      ST_READ_A:    if (ev_rd_a_o)    step_d = ST_WRITE_INV;
      ST_WRITE_INV: if (ev_wr_inv_o)  step_d = ST_READ_B;
      ST_READ_B:    if (ev_rd_b_o)    step_d = match_i ? ST_RESTORE : ST_FINISH;
      ST_RESTORE:   if (ev_restore_o) step_d = ST_FINISH;
      ST_FINISH:                      step_d = ST_IDLE;
      default:                        step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q      <= ST_IDLE;
      boot_pend_q <= AUTO_START;
    end else begin
      step_q <= step_d;
      if (accept_o) boot_pend_q <= 1'b0;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/bps_req.sv
`timescale 1ns/1ps
module bps_req
  import bps_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bps_step_e     step_i,
  input  logic          accept_i,
  input  logic [AW-1:0] probe_addr_i,
  input  logic          ev_rd_a_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          match_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] orig_q;

  function automatic logic [DW-1:0] invert_byte(input logic [DW-1:0] b);
    return ~b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      orig_q <= '0;
    end else begin
      if (accept_i)  addr_q <= probe_addr_i;
      if (ev_rd_a_i) orig_q <= rdata_i;
    end
  end

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    wdata_o = '0;
    unique case (step_i)
      ST_READ_A, ST_READ_B: req_o = 1'b1;
      ST_WRITE_INV: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = invert_byte(orig_q);
      end
      ST_RESTORE: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = orig_q;
      end
      default: ;
    endcase
  end

  assign addr_o  = addr_q;
  assign match_o = (rdata_i == invert_byte(orig_q));
endmodule

// File: rtl/bps_verdict.sv
`timescale 1ns/1ps
module bps_verdict
  import bps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bps_step_e step_i,
  input  logic      accept_i,
  input  logic      ev_rd_b_i,
  input  logic      match_i,
  output logic      done_o,
  output logic      ok_o,
  output logic      low_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_o  <= 1'b0;
      low_o <= 1'b0;
    end else if (accept_i) begin
      ok_o  <= 1'b0;
      low_o <= 1'b0;
    end else if (ev_rd_b_i) begin
      ok_o  <= match_i;
      low_o <= !match_i;
    end
  end

  assign done_o = (step_i == ST_FINISH);
endmodule

// File: rtl/bkup_probe_seq.sv
`timescale 1ns/1ps
module bkup_probe_seq
  import bps_pkg::*;
#(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter bit AUTO_START = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] probe_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          batt_ok_o,
  output logic          batt_low_o
);
  bps_step_e step;
  logic accept, ev_rd_a, ev_wr_inv, ev_rd_b, ev_restore, match;

  bps_ctrl #(.AUTO_START(AUTO_START)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(mem_ack_i),
    .match_i(match), .step_o(step), .accept_o(accept),
    .ev_rd_a_o(ev_rd_a), .ev_wr_inv_o(ev_wr_inv), .ev_rd_b_o(ev_rd_b),
    .ev_restore_o(ev_restore)
  );

  bps_req #(.AW(AW), .DW(DW)) req_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .accept_i(accept),
    .probe_addr_i(probe_addr_i), .ev_rd_a_i(ev_rd_a), .rdata_i(mem_rdata_i),
    .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .match_o(match)
  );

  bps_verdict verdict_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .accept_i(accept),
    .ev_rd_b_i(ev_rd_b), .match_i(match), .done_o(done_o),
    .ok_o(batt_ok_o), .low_o(batt_low_o)
  );

  assign busy_o = (step != ST_IDLE);
endmodule

// File: rtl/bps_chk.sv
`timescale 1ns/1ps
module bps_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          batt_ok_o,
  input logic          batt_low_o,
  input logic          ev_rd_b,
  input logic          ev_restore
);
  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(batt_ok_o && batt_low_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R10
  addr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !done_o) |-> $stable(mem_addr_o));

  // R11
  busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R6
  low_no_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore |-> !batt_low_o);

  // R5
  restore_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_b && mem_req_o) |=> (batt_ok_o == (mem_req_o && mem_we_o)));
endmodule

bind bkup_probe_seq bps_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .busy_o(busy_o), .done_o(done_o), .batt_ok_o(batt_ok_o),
  .batt_low_o(batt_low_o), .ev_rd_b(ev_rd_b), .ev_restore(ev_restore)
);

// File: tb/bkup_probe_seq_tb_top.sv
`timescale 1ns/1ps
module bkup_probe_seq_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] probe_addr_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i, busy_o, done_o, batt_ok_o, batt_low_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] mem [256];
  int  lat = 0;
  bit  block_next = 1'b0;
  int  nlog = 0;
  bit            log_we   [16];
  logic [AW-1:0] log_addr [16];
  logic [DW-1:0] log_data [16];
  logic got_ok, got_low;

  always #4 clk = ~clk;

  bkup_probe_seq #(.AW(AW), .DW(DW), .AUTO_START(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .probe_addr_i(probe_addr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .batt_ok_o(batt_ok_o), .batt_low_o(batt_low_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // memory model with optional one-shot write swallowing
  initial begin
    int cnt = 0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (rst_n && mem_req_o) begin
        if (cnt >= lat) begin
          cnt = 0;
          mem_ack_i = 1'b1;
          if (nlog < 16) begin
            log_we[nlog]   = mem_we_o;
            log_addr[nlog] = mem_addr_o;
            log_data[nlog] = mem_we_o ? mem_wdata_o : mem[mem_addr_o];
          end
          nlog++;
          if (mem_we_o) begin
            if (block_next) block_next = 1'b0;
            else mem[mem_addr_o] = mem_wdata_o;
          end else begin
            mem_rdata_i = mem[mem_addr_o];
          end
        end else cnt++;
      end else cnt = 0;
    end
  end

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 200) begin
      @(negedge clk);
      t++;
    end
    got_ok  = batt_ok_o;
    got_low = batt_low_o;
    chk("R11 busy during done", busy_o, 1'b1);
    @(negedge clk);
    chk("R8 done single pulse", done_o, 1'b0);
    chk("R11 busy drops after done", busy_o, 1'b0);
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    @(negedge clk);
    probe_addr_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 busy after start", busy_o, 1'b1);
    chk("R8 flags cleared at start", {batt_ok_o, batt_low_o}, 2'b00);
  endtask

  task automatic chk_op(input int i, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string rq);
    chk({rq, " op dir"},  log_we[i],   we);
    chk({rq, " op addr"}, log_addr[i], a);
    chk({rq, " op data"}, log_data[i], d);
  endtask

  task automatic t_reset_and_boot();
    mem[8'h3C] = 8'h5A;
    probe_addr_i = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy_o, done_o, batt_ok_o, batt_low_o, mem_req_o}, 5'b0);
    rst_n = 1'b1;
    wait_done();
    chk("R2 op count", nlog, 4);
    chk_op(0, 1'b0, 8'h3C, 8'h5A, "R2");
    chk_op(1, 1'b1, 8'h3C, 8'hA5, "R3");
    chk_op(2, 1'b0, 8'h3C, 8'hA5, "R4");
    chk_op(3, 1'b1, 8'h3C, 8'h5A, "R5");
    chk("R5 verdict", {got_ok, got_low}, 2'b10);
    chk("R5 memory restored", mem[8'h3C], 8'h5A);
  endtask

  task automatic t_weak_cell();
    nlog = 0;
    lat = 2;
    mem[8'h10] = 8'hF0;
    block_next = 1'b1;
    pulse_start(8'h10);
    wait_done();
    repeat (6) @(negedge clk);
    chk("R6 op count, no restore", nlog, 3);
    chk_op(0, 1'b0, 8'h10, 8'hF0, "R6");
    chk_op(1, 1'b1, 8'h10, 8'h0F, "R6");
    chk_op(2, 1'b0, 8'h10, 8'hF0, "R6");
    chk("R6 verdict", {got_ok, got_low}, 2'b01);
    chk("R8 verdict held", {batt_ok_o, batt_low_o, done_o}, 3'b010);
    chk("R6 memory untouched", mem[8'h10], 8'hF0);
  endtask

  task automatic t_start_while_busy();
    nlog = 0;
    lat = 3;
    mem[8'h77] = 8'h00;
    mem[8'h99] = 8'h12;
    pulse_start(8'h77);
    @(negedge clk);
    probe_addr_i = 8'h99;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R9 single run op count", nlog, 4);
    for (int i = 0; i < 4; i++) chk("R10 address captured", log_addr[i], 8'h77);
    chk("R9 verdict", {got_ok, got_low}, 2'b10);
    chk("R9 other location untouched", mem[8'h99], 8'h12);
  endtask

  task automatic t_edges_latency();
    nlog = 0;
    lat = 5;
    mem[8'hFF] = 8'hFF;
    pulse_start(8'hFF);
    wait_done();
    chk("R7 one op per ack (slow)", nlog, 4);
    chk_op(1, 1'b1, 8'hFF, 8'h00, "R3");
    chk("R5 all-ones verdict", {got_ok, got_low}, 2'b10);
    chk("R5 all-ones restored", mem[8'hFF], 8'hFF);
    nlog = 0;
    lat = 0;
    mem[8'h00] = 8'h00;
    pulse_start(8'h00);
    wait_done();
    chk("R7 one op per ack (fast)", nlog, 4);
    chk_op(1, 1'b1, 8'h00, 8'hFF, "R3");
    chk_op(2, 1'b0, 8'h00, 8'hFF, "R4");
    chk("R5 all-zeros restored", mem[8'h00], 8'h00);
    nlog = 0;
    lat = 1;
    mem[8'h55] = 8'hC3;
    pulse_start(8'h55);
    wait_done();
    chk_op(1, 1'b1, 8'h55, 8'h3C, "R3");
    chk_op(3, 1'b1, 8'h55, 8'hC3, "R5");
    chk("R8 ok verdict after low run", {got_ok, got_low}, 2'b10);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    t_reset_and_boot();
    t_weak_cell();
    t_start_while_busy();
    t_edges_latency();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule